// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block sits between a processor word port and a block-wide memory port. It holds a parameterised number of lines. Each line has a valid bit, a dirty bit, a tag and a block of several words. A byte address is split into a tag, a line index and an offset. The offset is made of a word-select field and a byte-within-word field.

A single parameter fixes the write behaviour when the block is built. With `WRITE_BACK = 1` the cache writes back and allocates on writes. Stores only touch the line and mark it modified. A modified line is copied out to memory before it is replaced. With `WRITE_BACK = 0` the cache writes through and does not allocate on writes. Every store is sent to memory as a single-word masked write. A store that misses leaves the cache untouched.

The processor holds `req_i` with a stable address and write data until `ready_o` is high. The access completes on that clock edge. The memory side works the same way. `mem_req_o` is held with a stable address, strobe and data until `mem_ack_i` is high for one cycle, and the transfer completes on that edge. A read transfer returns the whole block on `mem_rdata_i` in that cycle.

Top module: `cache_wp`

## Requirements
- R1: With default parameters the byte address splits into byte-in-word [1:0], word select [3:2], line index [7:4] and tag [31:8]. Memory transfers carry block-aligned addresses, with bits [3:0] equal to zero.
- R2: A hit requires the line's valid bit to be set and its stored tag to equal the address tag. A read hit raises `ready_o` in the cycle of the request, returns the selected word on `rdata_o`, and makes no memory request.
- R3: On a read miss the block is fetched with `mem_we_o` low and written into the line. The requested word is then returned in the cycle after `mem_ack_i`.
- R4: In write-through mode a write hit issues one memory write. Its strobe has only bit (word select) set, and the data sits in that word lane. The line's word is updated too. `ready_o` rises in the cycle of `mem_ack_i`, and no line ever becomes dirty.
- R5: In write-back mode a write hit updates only the line and marks it dirty. `ready_o` rises in the request cycle and there is no memory request.
- R6: In write-through mode a write miss issues only the masked memory write and leaves the cache unchanged. A later read of that block still misses.
- R7: In write-back mode a write miss first fetches the block into the line and then writes the word, leaving the line dirty.
- R8: In write-back mode, a miss to a valid dirty line first writes the whole old block to memory. That write uses the old tag's address and an all-ones strobe, and the fetch follows it. Clean or invalid lines are replaced with no write-back.
- R9: While `mem_req_o` is high and `mem_ack_i` is low, the request stays high on the next cycle with unchanged address, direction and strobe.
- R10: `ready_o` stays low in every cycle in which a memory transfer is outstanding without acknowledge.
- R11: Reset clears every valid and dirty bit. Out of reset `ready_o` and `mem_req_o` are low, and the first access to any line misses without a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Processor access request, held until ready |
| we_i | input | 1 | Access is a store |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | WORD_W | Store data |
| ready_o | output | 1 | Access completes this cycle |
| rdata_o | output | WORD_W | Load data, valid with ready on a load |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Transfer is a write |
| mem_addr_o | output | ADDR_W | Block-aligned transfer address |
| mem_wstrb_o | output | WORDS | Word enables of a write transfer |
| mem_wdata_o | output | WORDS*WORD_W | Write block data |
| mem_ack_i | input | 1 | Transfer completes this cycle |
| mem_rdata_i | input | WORDS*WORD_W | Read block data, valid with acknowledge |

## Verification
Three timings are checked:
- A load hit, and a store hit in write-back mode, must show `ready_o` 1 ns after the request is driven at a falling edge, with zero wait cycles.
- Every miss must return data only in the cycle after the last fill acknowledge.
- A write-through store must finish in the very cycle its memory write is acknowledged.

The bench drives at falling edges and samples just after. Its memory model acknowledges every transfer after a fixed two-cycle wait, so no sample lands on an edge.

For each access, a behavioural line model predicts three things: whether a stall is expected, the exact ordered list of memory transfers (direction, address, strobe), and the returned word. The bench compares all three. It also checks on every clock that held requests stay stable and that ready stays low.

// File: rtl/cache_wp_pkg.sv
package cache_wp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_wp_addr_split.sv
module cache_wp_addr_split #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 24,
  parameter int IDX_W  = 4,
  parameter int WOFF_W = 2,
  parameter int BOFF_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WOFF_W-1:0] woff_o
);
  localparam int WOFF_LSB = BOFF_W;
  localparam int IDX_LSB  = BOFF_W + WOFF_W;
  localparam int TAG_LSB  = IDX_LSB + IDX_W;

  logic [BOFF_W-1:0] unused_boff;

  assign tag_o       = addr_i[ADDR_W-1:TAG_LSB];
  assign idx_o       = addr_i[TAG_LSB-1:IDX_LSB];
  assign woff_o      = addr_i[IDX_LSB-1:WOFF_LSB];
  assign unused_boff = addr_i[BOFF_W-1:0];
endmodule

// File: rtl/cache_wp_tag_store.sv
module cache_wp_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             fill_i,
  input  logic             clean_i,
  input  logic             dirty_set_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_i) begin
        valid_q[idx_i] <= 1'b1;
        dirty_q[idx_i] <= 1'b0;
      end else if (clean_i) begin
        dirty_q[idx_i] <= 1'b0;
      end else if (dirty_set_i) begin
        dirty_q[idx_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_o |-> valid_o); // R5
endmodule

// File: rtl/cache_wp_data_store.sv
module cache_wp_data_store #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4,
  parameter int WOFF_W = 2
) (
  input  logic                      clk_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic                      fill_i,
  input  logic [WORDS*WORD_W-1:0]   fill_data_i,
  input  logic                      wr_i,
  input  logic [WOFF_W-1:0]         woff_i,
  input  logic [WORD_W-1:0]         wdata_i,
  output logic [WORDS*WORD_W-1:0]   block_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q [LINES];

    always_ff @(posedge clk_i) begin
      if (fill_i) begin
        word_q[idx_i] <= fill_data_i[w*WORD_W +: WORD_W];
      end else if (wr_i && (woff_i == WOFF_W'(w))) begin
        word_q[idx_i] <= wdata_i;
      end
    end

    assign block_o[w*WORD_W +: WORD_W] = word_q[idx_i];
  end
endmodule

// File: rtl/cache_wp_ctrl.sv
module cache_wp_ctrl
  import cache_wp_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic hit_i,
  input  logic victim_valid_i,
  input  logic victim_dirty_i,
  input  logic mem_ack_i,
  output logic ready_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic evict_o,
  output logic word_wr_o,
  output logic fill_o,
  output logic clean_o,
  output logic line_wr_o,
  output logic dirty_set_o
);
  cache_state_e state_q, state_d;
  logic victim_mod;

  assign victim_mod = WRITE_BACK && victim_valid_i && victim_dirty_i;

  always_comb begin
    state_d     = state_q;
    ready_o     = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    evict_o     = 1'b0;
    word_wr_o   = 1'b0;
    fill_o      = 1'b0;
    clean_o     = 1'b0;
    line_wr_o   = 1'b0;
    dirty_set_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (hit_i) begin
            if (!we_i) begin
              ready_o = 1'b1;
            end else if (WRITE_BACK) begin
              ready_o     = 1'b1;
              line_wr_o   = 1'b1;
              dirty_set_o = 1'b1;
            end else begin
              state_d = ST_WRITE;
            end
          end else if (we_i && !WRITE_BACK) begin
            state_d = ST_WRITE;
          end else if (victim_mod) begin
            state_d = ST_EVICT;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        evict_o   = 1'b1;
        if (mem_ack_i) begin
          clean_o = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          fill_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        word_wr_o = 1'b1;
        if (mem_ack_i) begin
          ready_o   = 1'b1;
          line_wr_o = hit_i;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  AST_STALL_ON_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |-> !ready_o); // R10
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o))); // R9
  AST_FILL_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i && req_i && !we_i) |=> ready_o); // R3
endmodule

// File: rtl/cache_wp.sv
module cache_wp
  import cache_wp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int WORDS      = 4,
  parameter int LINES      = 16,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic                    ready_o,
  output logic [WORD_W-1:0]       rdata_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [WORDS-1:0]        mem_wstrb_o,
  output logic [WORDS*WORD_W-1:0] mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [WORDS*WORD_W-1:0] mem_rdata_i
);
  localparam int BOFF_W  = $clog2(WORD_W / 8);
  localparam int WOFF_W  = $clog2(WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int OFF_W   = BOFF_W + WOFF_W;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int BLOCK_W = WORDS * WORD_W;

  logic [TAG_W-1:0]   a_tag, l_tag;
  logic [IDX_W-1:0]   a_idx;
  logic [WOFF_W-1:0]  a_woff;
  logic               l_valid, l_dirty, hit;
  logic [BLOCK_W-1:0] l_block;
  logic               evict, word_wr, fill, clean, line_wr, dirty_set;

  cache_wp_addr_split #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .WOFF_W(WOFF_W), .BOFF_W(BOFF_W)
  ) u_split (
    .addr_i (addr_i),
    .tag_o  (a_tag),
    .idx_o  (a_idx),
    .woff_o (a_woff)
  );

  cache_wp_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (a_idx),
    .tag_i       (a_tag),
    .fill_i      (fill),
    .clean_i     (clean),
    .dirty_set_i (dirty_set),
    .valid_o     (l_valid),
    .dirty_o     (l_dirty),
    .tag_o       (l_tag)
  );

  cache_wp_data_store #(
    .LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W), .WOFF_W(WOFF_W)
  ) u_data (
    .clk_i       (clk_i),
    .idx_i       (a_idx),
    .fill_i      (fill),
    .fill_data_i (mem_rdata_i),
    .wr_i        (line_wr),
    .woff_i      (a_woff),
    .wdata_i     (wdata_i),
    .block_o     (l_block)
  );

  assign hit = l_valid && (l_tag == a_tag);

  cache_wp_ctrl #(.WRITE_BACK(WRITE_BACK)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_i),
    .we_i           (we_i),
    .hit_i          (hit),
    .victim_valid_i (l_valid),
    .victim_dirty_i (l_dirty),
    .mem_ack_i      (mem_ack_i),
    .ready_o        (ready_o),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .evict_o        (evict),
    .word_wr_o      (word_wr),
    .fill_o         (fill),
    .clean_o        (clean),
    .line_wr_o      (line_wr),
    .dirty_set_o    (dirty_set)
  );

  // Write-back uses the resident tag; everything else the requested one.
  assign mem_addr_o  = evict ? {l_tag, a_idx, {OFF_W{1'b0}}} : {a_tag, a_idx, {OFF_W{1'b0}}};
  assign mem_wdata_o = evict ? l_block : {WORDS{wdata_i}};
  assign mem_wstrb_o = word_wr ? (WORDS'(1) << a_woff) : (mem_we_o ? {WORDS{1'b1}} : '0);
  assign rdata_o     = l_block[a_woff*WORD_W +: WORD_W];

  AST_READ_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !we_i) |-> (hit && !mem_req_o)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && req_i && $stable(addr_i)) |=> ($stable(mem_addr_o) && $stable(mem_wstrb_o))); // R9
  AST_FILL_NOT_OVER_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> !(l_valid && l_dirty)); // R8
  AST_WT_NO_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WRITE_BACK && req_i) |-> !l_dirty); // R4
  AST_WT_STORE_TO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WRITE_BACK && ready_o && we_i) |-> (mem_ack_i && mem_we_o && $onehot0(mem_wstrb_o))); // R4
  AST_WB_STORE_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WRITE_BACK && ready_o && we_i) |-> !mem_req_o); // R5
endmodule

// File: tb/cache_wp_bench.sv
module cache_wp_env #(
  parameter bit WB = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [3:0]  strb;
  } txn_t;

  logic         req, we, ready, mem_req, mem_we, ack;
  logic [31:0]  addr, wdata, rdata, mem_addr;
  logic [3:0]   mem_strb;
  logic [127:0] mem_wdata, mem_rdata;

  int n_checks = 0;
  int n_errors = 0;

  cache_wp #(.WRITE_BACK(WB)) u_cache_wp (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wstrb_o(mem_strb),
    .mem_wdata_o(mem_wdata), .mem_ack_i(ack), .mem_rdata_i(mem_rdata)
  );

  function automatic void chk(bit ok, string lbl, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s wb=%0d act=%h exp=%h", lbl, what, WB, act, exp);
    end
  endfunction

  function automatic logic [31:0] dflt(int wa);
    return 32'(wa) * 32'h9E37_79B1 ^ 32'h5A5A_0000;
  endfunction

  logic [31:0] mem  [int];
  logic [31:0] gold [int];
  txn_t obs_q[$];
  txn_t exp_q[$];

  // Memory model: two wait cycles, then a one-cycle acknowledge.
  int          cnt;
  bit          pend;
  logic [31:0] s_addr;
  logic [3:0]  s_strb;
  logic        s_we;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; cnt = 0; pend = 0; mem_rdata <= '0;
    end else begin
      if (pend)
        chk(mem_req && mem_addr == s_addr && mem_we == s_we && mem_strb == s_strb,
            "R9", mem_addr, s_addr, "held request");
      pend = mem_req && !ack;
      s_addr = mem_addr; s_we = mem_we; s_strb = mem_strb;
      if (ack) begin
        ack <= 1'b0; cnt = 0;
      end else if (mem_req) begin
        if (cnt == 2) begin
          int ba;
          txn_t t;
          ba = int'(mem_addr >> 2);
          ack <= 1'b1;
          for (int w = 0; w < 4; w++) begin
            if (mem_we) begin
              if (mem_strb[w]) mem[ba + w] = mem_wdata[w*32 +: 32];
            end else begin
              mem_rdata[w*32 +: 32] <= mem.exists(ba + w) ? mem[ba + w] : dflt(ba + w);
            end
          end
          t.we = mem_we; t.addr = mem_addr; t.strb = mem_strb;
          obs_q.push_back(t);
        end else begin
          cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_req && !ack) chk(!ready, "R10", 32'(ready), 32'd0, "ready while waiting");
  end

  bit          r_valid [16];
  bit          r_dirty [16];
  logic [23:0] r_tag   [16];

  function automatic logic [31:0] mk(int tag, int idx, int w);
    return {24'(tag), 4'(idx), 2'(w), 2'b00};
  endfunction

  function automatic void push(bit w, logic [31:0] a, logic [3:0] s);
    txn_t t;
    t.we = w; t.addr = a; t.strb = s;
    exp_q.push_back(t);
  endfunction

  task automatic do_op(bit wr, logic [31:0] a, logic [31:0] wd);
    logic [23:0] tg;
    logic [3:0]  ix;
    logic [1:0]  wo;
    logic [31:0] blk, rd, exp_rd;
    bit          hit, no_wait, evicted;
    int          waits, wa;
    string       lbl;
    tg = a[31:8]; ix = a[7:4]; wo = a[3:2]; blk = {a[31:4], 4'b0}; wa = int'(a >> 2);
    hit = r_valid[ix] && r_tag[ix] == tg;
    no_wait = hit && (WB || !wr);
    evicted = 0;
    exp_q.delete();
    obs_q.delete();
    if (WB) begin
      if (!hit) begin
        if (r_valid[ix] && r_dirty[ix]) begin
          push(1, {r_tag[ix], ix, 4'b0}, 4'hF);
          evicted = 1;
        end
        push(0, blk, 4'h0);
        r_valid[ix] = 1; r_tag[ix] = tg; r_dirty[ix] = 0;
      end
      if (wr) r_dirty[ix] = 1;
    end else begin
      if (wr) begin
        push(1, blk, 4'(1 << wo));
      end else if (!hit) begin
        push(0, blk, 4'h0);
        r_valid[ix] = 1; r_tag[ix] = tg;
      end
    end
    if (evicted)  lbl = "R8";
    else if (hit) lbl = wr ? (WB ? "R5" : "R4") : "R2";
    else if (wr)  lbl = WB ? "R7" : "R6";
    else          lbl = "R1 R3";
    exp_rd = gold.exists(wa) ? gold[wa] : dflt(wa);

    @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = wd;
    #1;
    waits = 0;
    while (!ready) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = rdata;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;

    chk((waits == 0) == no_wait, lbl, 32'(waits), no_wait ? 32'd0 : 32'd1, "stall cycles");
    if (!wr) chk(rd === exp_rd, lbl, rd, exp_rd, "load data");
    chk(obs_q.size() == exp_q.size(), lbl, 32'(obs_q.size()), 32'(exp_q.size()), "transfer count");
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++) begin
      chk(obs_q[i].we == exp_q[i].we && obs_q[i].addr == exp_q[i].addr && obs_q[i].strb == exp_q[i].strb,
          lbl, {obs_q[i].addr[31:5], obs_q[i].we, obs_q[i].strb},
          {exp_q[i].addr[31:5], exp_q[i].we, exp_q[i].strb}, "transfer");
    end
    if (wr) gold[wa] = wd;
  endtask

  initial begin
    logic [31:0] lf;
    done = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < 16; i++) begin r_valid[i] = 0; r_dirty[i] = 0; r_tag[i] = '0; end
    @(negedge clk);
    chk(!ready && !mem_req, "R11", {30'd0, ready, mem_req}, 32'd0, "outputs in reset");
    wait (rst_n);
    @(negedge clk);
    chk(!ready && !mem_req, "R11", {30'd0, ready, mem_req}, 32'd0, "outputs after reset");
    do_op(0, mk(1, 0, 0), 0);            // R11 first access misses, R3 fill
    do_op(0, mk(1, 0, 1), 0);            // R2 hit
    do_op(1, mk(1, 0, 2), 32'h1111_2222); // R4 / R5 write hit
    do_op(0, mk(1, 0, 2), 0);            // R2 updated word
    do_op(1, mk(2, 0, 1), 32'h3333_4444); // R6 / R7 write miss (R8 in write-back)
    do_op(0, mk(2, 0, 1), 0);            // R6 still a miss in write-through
    do_op(0, mk(1, 0, 2), 0);            // R8 dirty victim in write-back
    do_op(0, mk(3, 5, 3), 0);
    do_op(1, mk(3, 5, 0), 32'hAAAA_5555);
    do_op(0, mk(4, 5, 0), 0);            // R8 / clean replacement
    do_op(0, mk(3, 5, 0), 0);
    lf = WB ? 32'h1234_5678 : 32'h0BAD_F00D;
    for (int n = 0; n < 160; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      do_op(lf[8], mk(1 + int'(lf[2:1]), int'(lf[5:4]), int'(lf[7:6])), lf ^ 32'hC0DE_0000);
    end
    done = 1'b1;
  end
endmodule

module cache_wp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done_wb, done_wt;

  always #10 clk = ~clk;

  cache_wp_env #(.WB(1'b1)) u_env_wb (.clk(clk), .rst_n(rst_n), .done(done_wb));
  cache_wp_env #(.WB(1'b0)) u_env_wt (.clk(clk), .rst_n(rst_n), .done(done_wt));

  initial begin
    int cyc;
    int checks;
    int errors;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(done_wb && done_wt) && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    checks = u_env_wb.n_checks + u_env_wt.n_checks;
    errors = u_env_wb.n_errors + u_env_wt.n_errors;
    if (!(done_wb && done_wt)) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule